// File: doc/BRIEF.md
# NAND Command and Address Cycle Sequencer

This block turns a single request into the command and address cycles of a raw NAND bus. A request carries an opcode, an optional column address and an optional page address. The block puts the opcode on the bus as a command-latch cycle. It follows with the address bytes that the opcode and the device configuration call for, one bus byte per clock, each with a write strobe. For the two opcodes that need a confirm byte, it adds one idle cycle and then the confirm command.

After the last bus cycle it waits a fixed settling time. It then polls the ready/busy line until the device reports ready or a timeout window expires. The end of the sequence is marked by a one-clock done pulse. A timeout flag stays set until the next request is accepted.

Two configuration inputs shape the address phase. One selects a 16-bit bus, which halves the column for opcodes that are not byte-wide by nature. The other marks a device larger than 128 MiB, which needs a third page byte. The settling time and the timeout window are clock-cycle parameters.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset the block is idle. busy, cmd_latch, addr_latch, wr_strobe, done and timeout are all low.
- R2: A request is accepted in a cycle where busy is low and req_valid is high. In the next cycle the opcode appears on bus_byte with cmd_latch and wr_strobe high, and each later bus cycle carries exactly one byte.
- R3: When req_has_col is set, the column follows the opcode as address cycles: low byte first, then high byte. Opcodes 0x90 and 0xEC send only the low byte. When req_has_col is clear, no column byte is sent.
- R4: With cfg_bus16 set, the column is shifted right by one bit before it is sent, except for opcodes 0x90 and 0xEC, which send it unshifted.
- R5: When req_has_page is set, page bits 7:0 and then 15:8 follow the column as address cycles. Bits 23:16 follow them only when cfg_big is set. When req_has_page is clear, no page byte is sent.
- R6: Opcode 0x00 is followed by confirm 0x30, and opcode 0x05 by confirm 0xE0. Each confirm is sent as a command-latch cycle after exactly one cycle with cmd_latch, addr_latch and wr_strobe low. Other opcodes get no confirm.
- R7: For SETTLE_CYC cycles after the last bus cycle, rb_ready is ignored. Polling starts in the next cycle. When rb_ready is seen high in a polled cycle, done follows in the next cycle.
- R8: If rb_ready stays low for TMO_CYC polled cycles, done is raised with timeout high. timeout stays high until the next request is accepted and is low from the cycle after acceptance.
- R9: done is high for exactly one cycle per request, and busy is low in the cycle after it.
- R10: A request raised while busy is high is ignored. It neither alters the running sequence nor starts a new one.
- R11: cmd_latch and addr_latch are never high together, and wr_strobe is high exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_opcode | input | 8 | Command opcode |
| req_has_col | input | 1 | Column address present |
| req_col | input | 16 | Column address |
| req_has_page | input | 1 | Page address present |
| req_page | input | 24 | Page address |
| cfg_bus16 | input | 1 | Device bus is 16 bits wide |
| cfg_big | input | 1 | Device capacity above 128 MiB |
| rb_ready | input | 1 | Ready/busy line, high when ready |
| busy | output | 1 | Sequence in progress |
| cmd_latch | output | 1 | Command-latch enable |
| addr_latch | output | 1 | Address-latch enable |
| wr_strobe | output | 1 | Write strobe for the current bus byte |
| bus_byte | output | 8 | Byte driven onto the bus |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout | output | 1 | Ready was not seen within the window |

## Verification
The bench builds the block with SETTLE_CYC set to 3 and TMO_CYC set to 16. With these values the whole timeout window fits in a few dozen cycles. The bench can therefore reach an expired timeout, a ready seen on the final polled cycle, and a ready seen partway through polling. It sweeps six opcodes against all sixteen combinations of column present, page present, bus width and device size, so every address-cycle count and every confirm case is covered.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned COL_BITS   = 16;
  localparam int unsigned PAGE_BITS  = 24;
  localparam int unsigned COL_BYTES  = COL_BITS / BYTE_W;
  localparam int unsigned PAGE_BYTES = PAGE_BITS / BYTE_W;
  localparam int unsigned ADDR_SLOTS = COL_BYTES + PAGE_BYTES;
  localparam int unsigned SLOT_IW    = $clog2(ADDR_SLOTS + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_GAP, ST_CONF, ST_SETTLE, ST_POLL, ST_DONE
  } seq_state_e;

  localparam byte_t OP_READ0     = 8'h00;
  localparam byte_t OP_READ0_GO  = 8'h30;
  localparam byte_t OP_RNDOUT    = 8'h05;
  localparam byte_t OP_RNDOUT_GO = 8'hE0;
  localparam byte_t OP_READID    = 8'h90;
  localparam byte_t OP_PARAM     = 8'hEC;
endpackage

// File: rtl/nand_addr_plan.sv
`timescale 1ns/1ps
// Builds the packed list of address bytes and the optional confirm opcode
// for one request.
module nand_addr_plan
  import nand_seq_pkg::*;
(
  input  byte_t                opcode,
  input  logic                 has_col,
  input  logic [COL_BITS-1:0]  col,
  input  logic                 has_page,
  input  logic [PAGE_BITS-1:0] page,
  input  logic                 bus16,
  input  logic                 big,
  output byte_t                slot [ADDR_SLOTS],
  output logic [SLOT_IW-1:0]   slot_cnt,
  output logic                 need_conf,
  output byte_t                conf_op
);
  logic                narrow;
  logic [COL_BITS-1:0] col_eff;
  int unsigned         col_n;
  int unsigned         page_n;

  // Byte-wide opcodes: one column cycle, never shifted.
  assign narrow  = (opcode == OP_READID) || (opcode == OP_PARAM);
  assign col_eff = (bus16 && !narrow) ? (col >> 1) : col;

  always_comb begin
    logic [SLOT_IW-1:0] n;
    n = '0;
    for (int i = 0; i < ADDR_SLOTS; i++) slot[i] = '0;
    col_n  = narrow ? 1 : COL_BYTES;
    page_n = big ? PAGE_BYTES : PAGE_BYTES - 1;
    if (has_col) begin
      for (int b = 0; b < COL_BYTES; b++) begin
        if (b < col_n) begin
          slot[n] = col_eff[BYTE_W*b +: BYTE_W];
          n = n + SLOT_IW'(1);
        end
      end
    end
    if (has_page) begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        if (b < page_n) begin
          slot[n] = page[BYTE_W*b +: BYTE_W];
          n = n + SLOT_IW'(1);
        end
      end
    end
    slot_cnt = n;
  end

  always_comb begin
    need_conf = 1'b0;
    conf_op   = '0;
    if (opcode == OP_READ0) begin
      need_conf = 1'b1;
      conf_op   = OP_READ0_GO;
    end else if (opcode == OP_RNDOUT) begin
      need_conf = 1'b1;
      conf_op   = OP_RNDOUT_GO;
    end
  end
endmodule

// File: rtl/nand_wait_ctr.sv
`timescale 1ns/1ps
// Shared up-counter for the settling wait and the polling window.
module nand_wait_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || en)  cnt <= cnt_d;
  end
endmodule

// File: rtl/nand_cmd_seq.sv
`timescale 1ns/1ps
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 20,
  parameter int unsigned TMO_CYC    = 4000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [BYTE_W-1:0]    req_opcode,
  input  logic                 req_has_col,
  input  logic [COL_BITS-1:0]  req_col,
  input  logic                 req_has_page,
  input  logic [PAGE_BITS-1:0] req_page,
  input  logic                 cfg_bus16,
  input  logic                 cfg_big,
  input  logic                 rb_ready,
  output logic                 busy,
  output logic                 cmd_latch,
  output logic                 addr_latch,
  output logic                 wr_strobe,
  output logic [BYTE_W-1:0]    bus_byte,
  output logic                 done,
  output logic                 timeout
);
  localparam int unsigned SPAN = (SETTLE_CYC > TMO_CYC) ? SETTLE_CYC : TMO_CYC;
  localparam int unsigned CW   = $clog2(SPAN + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST    = CW'(TMO_CYC - 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // Address plan, computed from the live request and captured on accept.
  byte_t              plan_slot [ADDR_SLOTS];
  logic [SLOT_IW-1:0] plan_cnt;
  logic               plan_conf;
  byte_t              plan_conf_op;

  nand_addr_plan u_plan (
    .opcode    (req_opcode),
    .has_col   (req_has_col),
    .col       (req_col),
    .has_page  (req_has_page),
    .page      (req_page),
    .bus16     (cfg_bus16),
    .big       (cfg_big),
    .slot      (plan_slot),
    .slot_cnt  (plan_cnt),
    .need_conf (plan_conf),
    .conf_op   (plan_conf_op)
  );

  seq_state_e         state_q, state_d, post_addr;
  byte_t              op_q, conf_op_q;
  byte_t              slot_q [ADDR_SLOTS];
  logic [SLOT_IW-1:0] cnt_q, idx_q, idx_d, last_idx;
  logic               conf_q, tmo_q, tmo_d, accept;
  logic [CW-1:0]      wait_cnt;
  logic               wait_clr, wait_en;

  assign last_idx = cnt_q - SLOT_IW'(1);

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    tmo_d     = tmo_q;
    accept    = 1'b0;
    post_addr = conf_q ? ST_GAP : ST_SETTLE;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_CMD;
          tmo_d   = 1'b0;
        end
      end
      ST_CMD: begin
        if (cnt_q != '0) begin
          state_d = ST_ADDR;
          idx_d   = '0;
        end else begin
          state_d = post_addr;
        end
      end
      ST_ADDR: begin
        if (idx_q == last_idx) state_d = post_addr;
        else                   idx_d   = idx_q + SLOT_IW'(1);
      end
      ST_GAP:    state_d = ST_CONF;
      ST_CONF:   state_d = ST_SETTLE;
      ST_SETTLE: begin
        if (wait_cnt == SETTLE_LAST) state_d = ST_POLL;
      end
      ST_POLL: begin
        if (rb_ready) begin
          state_d = ST_DONE;
        end else if (wait_cnt == TMO_LAST) begin
          state_d = ST_DONE;
          tmo_d   = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      conf_op_q <= '0;
      conf_q    <= 1'b0;
      cnt_q     <= '0;
      idx_q     <= '0;
      tmo_q     <= 1'b0;
      for (int i = 0; i < ADDR_SLOTS; i++) slot_q[i] <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      tmo_q   <= tmo_d;
      if (accept) begin
        op_q      <= req_opcode;
        conf_op_q <= plan_conf_op;
        conf_q    <= plan_conf;
        cnt_q     <= plan_cnt;
        for (int i = 0; i < ADDR_SLOTS; i++) slot_q[i] <= plan_slot[i];
      end
    end
  end

  // Wait counter restarts on every state change.
  assign wait_clr = (state_d != state_q);
  assign wait_en  = (state_q == ST_SETTLE) || (state_q == ST_POLL);

  nand_wait_ctr #(.CW(CW)) u_wait (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (wait_clr),
    .en    (wait_en),
    .cnt   (wait_cnt)
  );

  // Bus outputs
  assign cmd_latch  = (state_q == ST_CMD) || (state_q == ST_CONF);
  assign addr_latch = (state_q == ST_ADDR);
  assign wr_strobe  = cmd_latch || addr_latch;
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign timeout    = tmo_q;

  always_comb begin
    unique case (state_q)
      ST_CMD:  bus_byte = op_q;
      ST_ADDR: bus_byte = slot_q[idx_q];
      ST_CONF: bus_byte = conf_op_q;
      default: bus_byte = '0;
    endcase
  end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
`timescale 1ns/1ps
module nand_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [7:0] req_opcode,
  input logic       busy,
  input logic       cmd_latch,
  input logic       addr_latch,
  input logic       wr_strobe,
  input logic [7:0] bus_byte,
  input logic       done,
  input logic       timeout
);
  a_r11_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_latch && addr_latch));

  a_r2_opcode_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (cmd_latch && wr_strobe && bus_byte == $past(req_opcode)));

  a_r6_gap_after_address: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch |=> !cmd_latch);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r8_timeout_raised_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

  a_r8_timeout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !(req_valid && !busy)) |=> timeout);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .req_valid  (req_valid),
  .req_opcode (req_opcode),
  .busy       (busy),
  .cmd_latch  (cmd_latch),
  .addr_latch (addr_latch),
  .wr_strobe  (wr_strobe),
  .bus_byte   (bus_byte),
  .done       (done),
  .timeout    (timeout)
);

// File: tb/nand_cmd_seq_bench.sv
`timescale 1ns/1ps
module nand_cmd_seq_bench;
  localparam int S = 3;
  localparam int T = 16;

  logic        clk, rst_n, req_valid, req_has_col, req_has_page;
  logic [7:0]  req_opcode;
  logic [15:0] req_col;
  logic [23:0] req_page;
  logic        cfg_bus16, cfg_big, rb_ready;
  logic        busy, cmd_latch, addr_latch, wr_strobe, done, timeout;
  logic [7:0]  bus_byte;

  nand_cmd_seq #(.SETTLE_CYC(S), .TMO_CYC(T)) u_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_has_col(req_has_col), .req_col(req_col), .req_has_page(req_has_page),
    .req_page(req_page), .cfg_bus16(cfg_bus16), .cfg_big(cfg_big),
    .rb_ready(rb_ready), .busy(busy), .cmd_latch(cmd_latch),
    .addr_latch(addr_latch), .wr_strobe(wr_strobe), .bus_byte(bus_byte),
    .done(done), .timeout(timeout)
  );

  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // rdy_delay < 0: ready never comes.
  task automatic run_seq(input logic [7:0] op, input bit hc, input logic [15:0] col,
                         input bit hp, input logic [23:0] pg, input bit b16,
                         input bit big, input int rdy_delay, input bit poke);
    logic [7:0]  eb [16];
    bit          ec [16];
    string       et [16];
    logic [7:0]  gb [16];
    bit          gc [16];
    bit          ga [16];
    int          gk [16];
    int          ne, n, elast, rdy_k, edone, done_k;
    bit          narrow, conf, etmo, got_tmo;
    logic [15:0] ce;
    ne = 1; eb[0] = op; ec[0] = 1'b1; et[0] = "R2";
    narrow = (op == 8'h90) || (op == 8'hEC);
    ce = (b16 && !narrow) ? col / 2 : col;
    if (hc) begin
      eb[ne] = ce[7:0]; ec[ne] = 1'b0; et[ne] = b16 ? "R4" : "R3"; ne++;
      if (!narrow) begin eb[ne] = ce[15:8]; ec[ne] = 1'b0; et[ne] = b16 ? "R4" : "R3"; ne++; end
    end
    if (hp) begin
      eb[ne] = pg[7:0];  ec[ne] = 1'b0; et[ne] = "R5"; ne++;
      eb[ne] = pg[15:8]; ec[ne] = 1'b0; et[ne] = "R5"; ne++;
      if (big) begin eb[ne] = pg[23:16]; ec[ne] = 1'b0; et[ne] = "R5"; ne++; end
    end
    conf = (op == 8'h00) || (op == 8'h05);
    if (conf) begin
      eb[ne] = (op == 8'h00) ? 8'h30 : 8'hE0; ec[ne] = 1'b1; et[ne] = "R6"; ne++;
    end
    elast = ne - 1 + (conf ? 1 : 0);
    if (rdy_delay < 0) begin
      rdy_k = 1 << 30; edone = elast + S + T + 1; etmo = 1'b1;
    end else begin
      rdy_k = elast + S + 1 + rdy_delay; edone = rdy_k + 1; etmo = 1'b0;
    end
    if (rdy_delay == 0) rdy_k = 0;   // ready held high throughout, settle must mask it

    @(negedge clk);
    req_opcode = op; req_has_col = hc; req_col = col; req_has_page = hp;
    req_page = pg; cfg_bus16 = b16; cfg_big = big; rb_ready = (rdy_k == 0);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; done_k = -1; got_tmo = 1'b0;
    for (int k = 0; k < 200; k++) begin
      rb_ready = (k >= rdy_k);
      if (poke && k == 1) begin req_valid = 1'b1; req_opcode = op ^ 8'h5A; end
      if (poke && k == 3) begin req_valid = 1'b0; req_opcode = op; end
      if (k == 0) begin
        chk(timeout == 1'b0, "R8", "timeout cleared after accept", timeout, 0);
        chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
      end
      chk(!(cmd_latch && addr_latch) && (wr_strobe == (cmd_latch || addr_latch)),
          "R11", "latch/strobe relation", {cmd_latch, addr_latch, wr_strobe}, 0);
      if (wr_strobe) begin
        if (n < 16) begin gb[n] = bus_byte; gc[n] = cmd_latch; ga[n] = addr_latch; gk[n] = k; end
        n++;
      end
      if (done) begin done_k = k; got_tmo = timeout; break; end
      @(negedge clk);
    end
    chk(n == ne, poke ? "R10" : "R3", "bus cycle count", n, ne);
    for (int i = 0; i < ne && i < n && i < 16; i++) begin
      chk(gb[i] == eb[i], et[i], "bus byte", gb[i], eb[i]);
      chk(gc[i] == ec[i] && ga[i] == !ec[i], et[i], "latch kind", {gc[i], ga[i]}, {ec[i], !ec[i]});
      chk(gk[i] == ((conf && i == ne - 1) ? i + 1 : i), et[i], "bus cycle slot",
          gk[i], (conf && i == ne - 1) ? i + 1 : i);
    end
    chk(done_k == edone, "R7", "done cycle", done_k, edone);
    chk(got_tmo == etmo, "R8", "timeout with done", got_tmo, etmo);
    rb_ready = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", "done single and idle after", {done, busy}, 0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        chk(busy == 1'b0 && wr_strobe == 1'b0, "R10", "ignored request started nothing",
            {busy, wr_strobe}, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    logic [7:0] ops [6];
    ops[0] = 8'h00; ops[1] = 8'h05; ops[2] = 8'h90;
    ops[3] = 8'hEC; ops[4] = 8'h80; ops[5] = 8'h60;
    rst_n = 1'b0; req_valid = 1'b0; req_opcode = '0; req_has_col = 1'b0;
    req_col = '0; req_has_page = 1'b0; req_page = '0; cfg_bus16 = 1'b0;
    cfg_big = 1'b0; rb_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !cmd_latch && !addr_latch && !wr_strobe && !done && !timeout,
        "R1", "reset outputs", {busy, cmd_latch, addr_latch, wr_strobe, done, timeout}, 0);

    for (int oi = 0; oi < 6; oi++) begin
      for (int c = 0; c < 16; c++) begin
        run_seq(ops[oi], c[0], 16'hA5C3 ^ 16'(c * 16'h1357), c[1],
                24'h3C5A96 + 24'(c * 24'h010203), c[2], c[3], 0, 1'b0);
      end
    end

    // R7: ready arrives partway through polling, and on the final polled cycle.
    run_seq(8'h00, 1'b1, 16'h1234, 1'b1, 24'hABCDEF, 1'b0, 1'b1, 5, 1'b0);
    run_seq(8'h80, 1'b1, 16'h0F0E, 1'b1, 24'h010203, 1'b1, 1'b0, T - 1, 1'b0);

    // R8: timeout, flag held while idle, then cleared by the next accept.
    run_seq(8'h05, 1'b1, 16'h4422, 1'b0, 24'h0, 1'b0, 1'b0, -1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      chk(timeout == 1'b1, "R8", "timeout held while idle", timeout, 1);
      @(negedge clk);
    end
    run_seq(8'h90, 1'b1, 16'h0020, 1'b0, 24'h0, 1'b1, 1'b0, 0, 1'b0);

    // R10: request pulsed while busy.
    run_seq(8'h00, 1'b1, 16'h8001, 1'b1, 24'h7E7E7E, 1'b1, 1'b1, 2, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule